// File: doc/BRIEF.md
# Ring Pointer Proximity Alarm Monitor

This block watches the write and read pointers of a circular elastic buffer that moves samples between two clock domains. Both pointers reach it already synchronised into one clock. It raises graded early-warning alarms when the pointers get close. The three levels are both pointers on the same slot, pointers one slot apart, and pointers two slots apart. Distance is measured around the ring in both directions.

Each alarm level has its own enable, held in a small configuration register that comes out of reset with all three levels armed. A qualifying condition latches a sticky status bit. Software clears that bit by writing a one to it. An optional auto-clear drops all status bits once the pointers have stayed clear for 64 samples in a row. A single combined output reports whether any armed level has latched.

The buffer storage and the synchronisers are outside this block. Integration consists of wiring the two pointer buses and the control strobes, and routing the combined alarm to wherever it is needed.

Top module: `ptr_guard_alarm`

## Requirements
- R1: When `wr_ptr` equals `rd_ptr` on a rising clock edge and level 0 is enabled, `alarm_sticky[0]` reads 1 after that edge.
- R2: When the pointers differ by exactly one slot modulo `DEPTH` (default 8), in either direction and including across the wrap, and level 1 is enabled, `alarm_sticky[1]` reads 1 after that edge.
- R3: When the pointers differ by exactly two slots modulo `DEPTH`, in either direction, and level 2 is enabled, `alarm_sticky[2]` reads 1 after that edge. A distance of three or more slots in both directions sets no bit.
- R4: The enable vector (bit 0 collision, bit 1 one apart, bit 2 two apart) is loaded from `cfg_alarm_en` on an edge where `cfg_we` is 1. It resets to 3'b111. A level whose enable is 0 never sets its status bit.
- R5: When `cfg_auto_clr` has been loaded as 1, all status bits clear on the 64th consecutive edge at which no enabled condition is present. Any edge with an enabled condition restarts that count. When auto-clear is 0, status bits stay set no matter how long the pointers stay clear.
- R6: A 1 in `clr_w1c[i]` clears `alarm_sticky[i]` at that edge, and other bits are untouched. If the condition for bit i is enabled and present at the same edge, the bit stays set.
- R7: `alarm_any` is 1 exactly when some bit of `alarm_sticky` is set and its level is currently enabled.
- R8: During and right after reset, `alarm_sticky` is 0, `alarm_any` is 0 and auto-clear is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the common pointer domain |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_ptr | input | PTR_W | Synchronised write pointer |
| rd_ptr | input | PTR_W | Synchronised read pointer |
| cfg_we | input | 1 | Load strobe for the enable and auto-clear settings |
| cfg_alarm_en | input | 3 | Per-level enables written on `cfg_we` |
| cfg_auto_clr | input | 1 | Auto-clear setting written on `cfg_we` |
| clr_w1c | input | 3 | Write-one-to-clear strobes for the status bits |
| alarm_sticky | output | 3 | Latched alarm status: bit 0 collision, bit 1 one apart, bit 2 two apart |
| alarm_any | output | 1 | OR of the status bits whose level is enabled |

## Verification
Every status bit is registered. A pointer pair, clear strobe or configuration write applied before an edge shows up in `alarm_sticky` just after that edge. `alarm_any` follows combinationally from the registered bits and the registered enables, so it also changes at that same edge. The driver applies each stimulus at the falling edge and queues the expected status computed from the requirements. The monitor pops one entry two nanoseconds after each following rising edge, which gives a one-cycle latency check for every stimulus. The auto-clear cases count exactly 63 and then 64 clear edges after the last alarmed edge.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

    localparam int NUM_LEVELS = 3;

    localparam int LVL_COLLIDE = 0;
    localparam int LVL_ONE_OFF = 1;
    localparam int LVL_TWO_OFF = 2;

    typedef struct packed {
        logic [NUM_LEVELS-1:0] level_en;
        logic                  auto_clr;
    } cfg_t;

    typedef struct packed {
        logic [NUM_LEVELS-1:0] sticky;
        cfg_t                  cfg;
    } alarm_state_t;

    localparam cfg_t CFG_RESET = '{level_en: '1, auto_clr: 1'b0};

endpackage

// File: rtl/ppa_distance.sv
module ppa_distance
    import ppa_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input  logic [PTR_W-1:0]      wr_ptr,
    input  logic [PTR_W-1:0]      rd_ptr,
    output logic [NUM_LEVELS-1:0] near
);

    logic [PTR_W-1:0] gap_fwd;
    logic [PTR_W-1:0] gap_bwd;

    always_comb begin
        // wrap-around subtraction is the modulo-DEPTH distance
        gap_fwd = wr_ptr - rd_ptr;
        gap_bwd = rd_ptr - wr_ptr;
    end

    generate
        for (genvar lvl = 0; lvl < NUM_LEVELS; lvl++) begin : g_level
            always_comb begin
                near[lvl] = (gap_fwd == PTR_W'(lvl)) || (gap_bwd == PTR_W'(lvl));
            end
        end
    endgenerate

endmodule

// File: rtl/ppa_good_run.sv
module ppa_good_run #(
    parameter int RUN_LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic quiet,
    input  logic auto_en,
    output logic fire
);

    localparam int CNT_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        fire  = 1'b0;
        if (!quiet) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            // run complete: release and restart, or hold saturated
            fire  = auto_en;
            cnt_d = auto_en ? '0 : LAST;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/ptr_guard_alarm.sv
module ptr_guard_alarm
    import ppa_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int RUN_LEN = 64,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PTR_W-1:0]      wr_ptr,
    input  logic [PTR_W-1:0]      rd_ptr,
    input  logic                  cfg_we,
    input  logic [NUM_LEVELS-1:0] cfg_alarm_en,
    input  logic                  cfg_auto_clr,
    input  logic [NUM_LEVELS-1:0] clr_w1c,
    output logic [NUM_LEVELS-1:0] alarm_sticky,
    output logic                  alarm_any
);

    alarm_state_t          st_d;
    alarm_state_t          st_q;
    logic [NUM_LEVELS-1:0] near;
    logic [NUM_LEVELS-1:0] hit;
    logic                  quiet;
    logic                  run_fire;
    logic [NUM_LEVELS-1:0] en_q;

    ppa_distance #(
        .PTR_W (PTR_W)
    ) u_distance (
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .near   (near)
    );

    ppa_good_run #(
        .RUN_LEN (RUN_LEN)
    ) u_good_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .quiet   (quiet),
        .auto_en (st_q.cfg.auto_clr),
        .fire    (run_fire)
    );

    always_comb begin
        hit   = near & st_q.cfg.level_en;
        quiet = ~|hit;
    end

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.cfg.level_en = cfg_alarm_en;
            st_d.cfg.auto_clr = cfg_auto_clr;
        end
        if (run_fire) begin
            st_d.sticky = '0;
        end else begin
            st_d.sticky = st_q.sticky & ~clr_w1c;
        end
        // a live condition wins over any clear in the same cycle
        st_d.sticky = st_d.sticky | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sticky <= '0;
            st_q.cfg    <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        en_q         = st_q.cfg.level_en;
        alarm_sticky = st_q.sticky;
        alarm_any    = |(st_q.sticky & st_q.cfg.level_en);
    end

endmodule

// File: rtl/ppa_checker.sv
module ppa_checker #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [2:0]       clr_w1c,
    input logic [2:0]       en_q,
    input logic [2:0]       alarm_sticky,
    input logic             alarm_any
);

    logic [PTR_W-1:0] span_f;
    logic [PTR_W-1:0] span_b;
    logic             at_one;
    logic             at_two;

    always_comb begin
        span_f = wr_ptr - rd_ptr;
        span_b = rd_ptr - wr_ptr;
        at_one = (span_f == PTR_W'(1)) || (span_b == PTR_W'(1));
        at_two = (span_f == PTR_W'(2)) || (span_b == PTR_W'(2));
    end

    AST_COLLIDE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr == rd_ptr && en_q[0]) |=> alarm_sticky[0]); // R1

    AST_ONE_OFF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (at_one && en_q[1]) |=> alarm_sticky[1]); // R2

    AST_TWO_OFF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (at_two && en_q[2]) |=> alarm_sticky[2]); // R3

    AST_MASKED_COLLIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[0] && !alarm_sticky[0]) |=> !alarm_sticky[0]); // R4

    AST_MASKED_TWO_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[2] && !alarm_sticky[2]) |=> !alarm_sticky[2]); // R4

    AST_W1C_ONE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w1c[1] && !at_one) |=> !alarm_sticky[1]); // R6

    AST_ANY_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_any |-> (alarm_sticky != 3'b000)); // R7

endmodule

bind ptr_guard_alarm ppa_checker #(
    .PTR_W (PTR_W)
) u_ppa_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ptr       (wr_ptr),
    .rd_ptr       (rd_ptr),
    .clr_w1c      (clr_w1c),
    .en_q         (en_q),
    .alarm_sticky (alarm_sticky),
    .alarm_any    (alarm_any)
);

// File: tb/test_ptr_guard_alarm.sv
`timescale 1ns/1ps
module test_ptr_guard_alarm;

    localparam int DEPTH   = 8;
    localparam int PTR_W   = 3;
    localparam int RUN_LEN = 64;

    logic             clk;
    logic             rst_n;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             cfg_we;
    logic [2:0]       cfg_alarm_en;
    logic             cfg_auto_clr;
    logic [2:0]       clr_w1c;
    logic [2:0]       alarm_sticky;
    logic             alarm_any;

    int checks   = 0;
    int failures = 0;

    typedef struct {
        logic [2:0] st;
        logic       any;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    // requirement model state
    logic [2:0] m_en     = 3'b111;
    logic       m_auto   = 1'b0;
    logic [2:0] m_sticky = 3'b000;
    int         m_run    = 0;

    ptr_guard_alarm #(
        .DEPTH   (DEPTH),
        .RUN_LEN (RUN_LEN)
    ) i_ptr_guard_alarm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ptr       (wr_ptr),
        .rd_ptr       (rd_ptr),
        .cfg_we       (cfg_we),
        .cfg_alarm_en (cfg_alarm_en),
        .cfg_auto_clr (cfg_auto_clr),
        .clr_w1c      (clr_w1c),
        .alarm_sticky (alarm_sticky),
        .alarm_any    (alarm_any)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic report(input string tag, input logic [2:0] st, input logic any,
                          input logic [2:0] est, input logic eany);
        checks++;
        if (st !== est || any !== eany) begin
            failures++;
            $display("FAIL %s actual sticky=%b any=%b expected sticky=%b any=%b",
                     tag, st, any, est, eany);
        end
    endtask

    // driver: one stimulus per cycle, expected result queued for the next edge
    task automatic step(input int wr, input int rd, input logic [2:0] clr,
                        input logic we, input logic [2:0] en, input logic au,
                        input string tag);
        logic [2:0] cond;
        logic [2:0] hit;
        logic       fire;
        int         f;
        int         b;
        exp_t       e;
        @(negedge clk);
        wr_ptr       = PTR_W'(wr);
        rd_ptr       = PTR_W'(rd);
        clr_w1c      = clr;
        cfg_we       = we;
        cfg_alarm_en = en;
        cfg_auto_clr = au;
        f = (wr - rd + DEPTH) % DEPTH;
        b = (rd - wr + DEPTH) % DEPTH;
        cond[0] = (f == 0);
        cond[1] = (f == 1) || (b == 1);
        cond[2] = (f == 2) || (b == 2);
        hit  = cond & m_en;
        fire = 1'b0;
        if (hit != 3'b000) begin
            m_run = 0;
        end else if (m_run == RUN_LEN - 1) begin
            fire  = m_auto;
            m_run = m_auto ? 0 : RUN_LEN - 1;
        end else begin
            m_run++;
        end
        m_sticky = (fire ? 3'b000 : (m_sticky & ~clr)) | hit;
        if (we) begin
            m_en   = en;
            m_auto = au;
        end
        e.st  = m_sticky;
        e.any = |(m_sticky & m_en);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic ptrs(input int wr, input int rd, input string tag);
        step(wr, rd, 3'b000, 1'b0, 3'b000, 1'b0, tag);
    endtask

    task automatic wipe(input logic [2:0] bits, input string tag);
        step(0, 4, bits, 1'b0, 3'b000, 1'b0, tag);
    endtask

    task automatic config_write(input logic [2:0] en, input logic au, input string tag);
        step(0, 4, 3'b000, 1'b1, en, au, tag);
    endtask

    // monitor: compares one queued expectation just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                report(e.tag, alarm_sticky, alarm_any, e.st, e.any);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=sequence complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n        = 1'b0;
        wr_ptr       = '0;
        rd_ptr       = 3'd4;
        cfg_we       = 1'b0;
        cfg_alarm_en = 3'b000;
        cfg_auto_clr = 1'b0;
        clr_w1c      = 3'b000;
        repeat (3) @(posedge clk);
        #1;
        report("R8 in reset", alarm_sticky, alarm_any, 3'b000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        report("R8 after release", alarm_sticky, alarm_any, 3'b000, 1'b0);

        ptrs(0, 4, "R8 idle after reset");
        ptrs(3, 3, "R1 collision with reset enables R4");
        wipe(3'b001, "R6 clear collision");
        ptrs(5, 4, "R2 one ahead");
        wipe(3'b010, "R6 clear one-off");
        ptrs(4, 5, "R2 one behind");
        ptrs(0, 7, "R2 one ahead across wrap");
        wipe(3'b010, "R6 clear one-off again");
        ptrs(0, 6, "R3 two ahead across wrap");
        wipe(3'b001, "R6 clear of other bit leaves two-off");
        wipe(3'b100, "R6 clear two-off");
        ptrs(7, 1, "R3 two behind across wrap");
        ptrs(3, 0, "R3 distance three no new bit");
        ptrs(1, 5, "R3 distance four no new bit");
        wipe(3'b111, "R6 clear all");
        ptrs(2, 2, "R1 collision again");
        step(2, 2, 3'b001, 1'b0, 3'b000, 1'b0, "R6 set wins over clear");
        wipe(3'b001, "R6 clear after condition gone");

        config_write(3'b110, 1'b0, "R4 disable collision");
        ptrs(6, 6, "R4 masked collision stays clear");
        ptrs(6, 5, "R4 one-off still armed");
        config_write(3'b100, 1'b0, "R7 mask latched one-off");
        ptrs(1, 3, "R7 two-off raises any");
        config_write(3'b111, 1'b0, "R7 unmask shows all bits");
        wipe(3'b111, "R6 clear all again");

        ptrs(4, 4, "R5 alarm with auto-clear off");
        for (int i = 0; i < 70; i++) ptrs(0, 4, "R5 no auto-clear when off");
        wipe(3'b111, "R6 clear before auto-clear");
        config_write(3'b111, 1'b1, "R5 enable auto-clear");

        ptrs(5, 5, "R5 raise before run");
        for (int i = 0; i < RUN_LEN - 1; i++) ptrs(0, 4, "R5 held during run");
        ptrs(0, 4, "R5 cleared at 64th quiet edge");

        ptrs(2, 3, "R5 raise again");
        for (int i = 0; i < 30; i++) ptrs(0, 4, "R5 partial run");
        ptrs(2, 0, "R5 condition restarts run");
        for (int i = 0; i < RUN_LEN - 1; i++) ptrs(0, 4, "R5 held after restart");
        ptrs(0, 4, "R5 cleared after restart");

        config_write(3'b011, 1'b1, "R4 disable two-off with auto-clear");
        ptrs(1, 3, "R5 masked level does not restart run");
        ptrs(1, 3, "R4 masked two-off stays clear");

        repeat (3) @(posedge clk);
        #3;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule